// File: doc/BRIEF.md
# Parallel-Load Serial-Output Shift Register

This block is a chain of `N` one-bit storage stages, eight by default. All stages share one clock. One mode input chooses between two actions. With the mode input low, the chain shifts by one stage on every rising clock edge, and a serial data input fills the first stage. With the mode input high, a whole word is taken in at once from `N` parallel inputs. It is used to turn a parallel word into a bit stream, or to queue words and send them out serially.

A parameter picks the style of the parallel load. In the clocked style the word is captured on the rising clock edge. In the level-sensitive style each stage is forced to its parallel input for as long as the mode input stays high, with no clock edge needed. Shifting is clocked in both styles. Three taps come out: the last stage, which is the main serial output, and the two stages just before it. Registers are chained by wiring the last-stage output of one block to the serial input of the next, all on the same clock.

Top module: `shreg_piso`

## Requirements
- R1: The register has `N` stages (default 8, at least 3). Stage 1 is bit 0 of the internal word. `serialOut` carries stage `N`, `tapLag1` carries stage `N-1` and `tapLag2` carries stage `N-2`.
- R2: With `loadMode` low, each rising clock edge moves every stage k (k ≥ 2) to the old value of stage k-1, and stage 1 takes `serialIn`. `parallelIn` has no effect in this mode.
- R3: With `ASYNC_LOAD` = 0 and `loadMode` high, every stage takes its own `parallelIn` bit on the rising clock edge. Before that edge the stages keep their values.
- R4: With `ASYNC_LOAD` = 1 and `loadMode` high, every stage follows its `parallelIn` bit at once, without any clock edge, and keeps following it across clock edges.
- R5: With `ASYNC_LOAD` = 1, once `loadMode` has gone low before a rising edge, that edge shifts as in R2, starting from the word that was loaded.
- R6: When the `serialOut` of one block feeds the `serialIn` of a second block on the same clock, the pair shifts as a single register of 2·`N` stages.
- R7: `parallelIn[i]` loads stage i+1. After a load, the shift sequence presents `parallelIn[N-1]` on `serialOut` first and then the lower bits in descending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; all updates except the level-sensitive load happen on its rising edge |
| loadMode | input | 1 | High: parallel load; low: serial shift |
| serialIn | input | 1 | Serial data into stage 1 |
| parallelIn | input | N | Parallel word; bit i goes to stage i+1 |
| tapLag2 | output | 1 | Stage N-2 |
| tapLag1 | output | 1 | Stage N-1 |
| serialOut | output | 1 | Stage N, the serial output |

## Verification
On every clock edge, the assertions check that a shift cycle moves the whole stage word by one place with the serial bit entering at the bottom. They also check that a clocked load leaves exactly the previous cycle's parallel word in the stages, and that in the level-sensitive style the stages equal the parallel inputs whenever the mode input is high. Three things can only be shown by the bench's scenarios: that the level-sensitive load takes effect between clock edges, that the clocked style keeps its contents until the edge, and that two chained blocks act as one longer register. The bench sweeps all 256 parallel words and follows each load with a full eight-bit shift-out.

// File: rtl/shreg_pkg.sv
`timescale 1ns/100ps
package shreg_pkg;

  // Strobes from the mode decoder to the stage datapath
  typedef struct packed {
    logic shiftEn;    // clocked shift this cycle
    logic syncLoad;   // clocked parallel capture
    logic asyncLoad;  // level-sensitive parallel force
  } ctrlStrobes_t;

  localparam int MIN_STAGES = 3;

endpackage

// File: rtl/shreg_ctrl.sv
`timescale 1ns/100ps
module shreg_ctrl
  import shreg_pkg::*;
#(
  parameter bit ASYNC_LOAD = 1'b0
) (
  input  logic         loadMode,
  output ctrlStrobes_t strobes
);

  // The parameter decides which load strobe the mode input can raise
  generate
    if (ASYNC_LOAD) begin : gAsyncMode
      always_comb begin
        strobes.shiftEn   = ~loadMode;
        strobes.syncLoad  = 1'b0;
        strobes.asyncLoad = loadMode;
      end
    end else begin : gSyncMode
      always_comb begin
        strobes.shiftEn   = ~loadMode;
        strobes.syncLoad  = loadMode;
        strobes.asyncLoad = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/shreg_datapath.sv
`timescale 1ns/100ps
module shreg_datapath
  import shreg_pkg::*;
#(
  parameter int N          = 8,
  parameter bit ASYNC_LOAD = 1'b0
) (
  input  logic         clk,
  input  ctrlStrobes_t strobes,
  input  logic         serialIn,
  input  logic [N-1:0] parallelIn,
  output logic [N-1:0] stages
);

  logic [N-1:0] shiftNext;
  assign shiftNext = {stages[N-2:0], serialIn};

  // Assertion-only marker that one edge has been seen, so $past is valid
  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  generate
    if (!ASYNC_LOAD) begin : gSync
      always_ff @(posedge clk) begin
        if (strobes.syncLoad)     stages <= parallelIn;
        else if (strobes.shiftEn) stages <= shiftNext;
      end

      // R3: a clocked load leaves last cycle's parallel word in the stages
      assert_sync_load_R3: assert property (@(posedge clk) disable iff (!pastValid)
        $past(strobes.syncLoad) |-> stages == $past(parallelIn));
    end else begin : gAsync
      for (genvar i = 0; i < N; i++) begin : gBit
        logic setB, clrB, bitQ;
        assign setB = strobes.asyncLoad & parallelIn[i];
        assign clrB = strobes.asyncLoad & ~parallelIn[i];
        always_ff @(posedge clk or posedge setB or posedge clrB) begin
          if (setB)                 bitQ <= 1'b1;
          else if (clrB)            bitQ <= 1'b0;
          else if (strobes.shiftEn) bitQ <= shiftNext[i];
        end
        assign stages[i] = bitQ;
      end

      // R4: while the force is active the stages mirror the parallel pins
      assert_async_follow_R4: assert property (@(posedge clk)
        strobes.asyncLoad |-> stages == parallelIn);
    end
  endgenerate

  // R2: exactly one action is selected on every cycle
  assert_one_action_R2: assert property (@(posedge clk)
    $countones({strobes.shiftEn, strobes.syncLoad, strobes.asyncLoad}) == 1);

  // R2, R5: two shift cycles in a row move the word by one place
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!pastValid)
    ($past(strobes.shiftEn) && strobes.shiftEn) |->
      stages == {$past(stages[N-2:0]), $past(serialIn)});

endmodule

// File: rtl/shreg_piso.sv
`timescale 1ns/100ps
module shreg_piso
  import shreg_pkg::*;
#(
  parameter int N          = 8,
  parameter bit ASYNC_LOAD = 1'b0
) (
  input  logic         clk,
  input  logic         loadMode,
  input  logic         serialIn,
  input  logic [N-1:0] parallelIn,
  output logic         tapLag2,
  output logic         tapLag1,
  output logic         serialOut
);

  localparam int LAST = N - 1;

  ctrlStrobes_t strobes;
  logic [N-1:0] stages;

  shreg_ctrl #(.ASYNC_LOAD(ASYNC_LOAD)) i_ctrl (
    .loadMode (loadMode),
    .strobes  (strobes)
  );

  shreg_datapath #(.N(N), .ASYNC_LOAD(ASYNC_LOAD)) i_datapath (
    .clk        (clk),
    .strobes    (strobes),
    .serialIn   (serialIn),
    .parallelIn (parallelIn),
    .stages     (stages)
  );

  // R1: taps from the last three stages
  assign serialOut = stages[LAST];
  assign tapLag1   = stages[LAST-1];
  assign tapLag2   = stages[LAST-2];

  // R1: the stage count must leave room for three taps
  initial assert_depth_R1: assert (N >= MIN_STAGES);

endmodule

// File: tb/test_shreg_piso.sv
`timescale 1ns/100ps
module test_shreg_piso;

  localparam int N = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         loadMode, serialIn;
  logic [N-1:0] parallelIn;
  logic [N-1:0] zeroWord;
  logic hL2, hL1, hOut, aL2, aL1, aOut, tL2, tL1, tOut;

  int checks = 0;
  int fails  = 0;

  assign zeroWord = '0;

  shreg_piso #(.N(N), .ASYNC_LOAD(1'b0)) i_shreg_piso (
    .clk(clk), .loadMode(loadMode), .serialIn(serialIn), .parallelIn(parallelIn),
    .tapLag2(hL2), .tapLag1(hL1), .serialOut(hOut));

  shreg_piso #(.N(N), .ASYNC_LOAD(1'b1)) i_shreg_piso_async (
    .clk(clk), .loadMode(loadMode), .serialIn(serialIn), .parallelIn(parallelIn),
    .tapLag2(aL2), .tapLag1(aL1), .serialOut(aOut));

  // R6: second block chained behind the first
  shreg_piso #(.N(N), .ASYNC_LOAD(1'b0)) i_shreg_piso_tail (
    .clk(clk), .loadMode(loadMode), .serialIn(hOut), .parallelIn(zeroWord),
    .tapLag2(tL2), .tapLag1(tL1), .serialOut(tOut));

  function automatic logic [2:0] tapsOf(input logic [N-1:0] m);
    return {m[N-1], m[N-2], m[N-3]};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: taps {out,lag1,lag2} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [N-1:0] headM, asyncM, tailM;
    logic [N-1:0] pat;
    headM = '0; asyncM = '0; tailM = '0;
    loadMode = 1'b0; serialIn = 1'b0; parallelIn = '0;
    @(negedge clk);
    for (int w = 0; w < 256; w++) begin
      pat = N'((w * 37 + 11) & 8'hFF);
      parallelIn = N'(w);
      loadMode   = 1'b1;
      #1;
      // R4: forced load visible with no clock edge since the mode rose
      check("R4 async load without edge", {aOut, aL1, aL2}, tapsOf(N'(w)));
      // R3: clocked style still holds before the edge
      if (w > 0) check("R3 hold before edge", {hOut, hL1, hL2}, tapsOf(headM));
      @(negedge clk);
      headM = N'(w); asyncM = N'(w); tailM = '0;
      check("R3 R7 clocked load", {hOut, hL1, hL2}, tapsOf(headM));
      check("R4 async held across edge", {aOut, aL1, aL2}, tapsOf(asyncM));
      check("R6 tail load", {tOut, tL1, tL2}, tapsOf(tailM));
      loadMode = 1'b0;
      #1;
      parallelIn = ~N'(w);  // R2: must be ignored while shifting
      for (int k = 0; k < N; k++) begin
        serialIn = pat[k];
        @(negedge clk);
        tailM  = {tailM[N-2:0], headM[N-1]};
        headM  = {headM[N-2:0], pat[k]};
        asyncM = {asyncM[N-2:0], pat[k]};
        check("R2 R7 shift", {hOut, hL1, hL2}, tapsOf(headM));
        check("R5 async shift", {aOut, aL1, aL2}, tapsOf(asyncM));
        check("R6 R1 chained shift", {tOut, tL1, tL2}, tapsOf(tailM));
      end
    end
    finishRun();
  end

endmodule